// File: doc/BRIEF.md
# Periodic Budget Server Gate

This block decides, tick by tick, which of a small set of periodic servers may use a shared processor or memory port. Each server owns a period and a budget, both counted in ticks, and is tied to one memory color, meaning a group of DRAM ranks. The budget is loaded at every period boundary and any unused remainder is thrown away. While a server holds the grant, each tick takes one unit from its budget. A server is eligible only when three things hold together: budget is left, its queue reports pending work, and its memory color is not locked by a refresh. Pending refresh lock or unlock activity outranks every server. Among eligible servers, the one with the lowest index wins.

The grant is registered and moves only on clock edges where `tick` is high. The grant held after a tick covers the interval up to the next tick, and that next tick charges it one budget unit. For each server the block also reports the remaining budget and a suspended flag.

Top module: `srv_gate`

## Requirements
- R1: While `rst` is high on a clock edge, `grant` is cleared, every `suspended` bit is set, each `budget_left` is loaded from its `cfg_budget`, and each period position returns to zero.
- R2: Each tick advances a server's period position. On the tick where the position plus one reaches `cfg_period`, the position wraps to zero and the budget is loaded from `cfg_budget`. Boundaries therefore fall every `cfg_period` ticks after reset. A period of 0 or 1 reloads on every tick.
- R3: At a boundary the budget is set to `cfg_budget`. Any unused remainder is discarded and never added to it.
- R4: On a tick that is not a boundary, the server that holds the grant loses one budget unit, saturating at zero. Budgets do not change between ticks.
- R5: When a boundary and a charge fall on the same tick, the budget ends at `cfg_budget`.
- R6: On a tick, server i is eligible only if its updated budget is non-zero, `queue_nempty[i]` is 1 and `color_lock[i]` is 0.
- R7: If `refresh_pend` is 1 on a tick, no server is granted for the interval that follows.
- R8: Otherwise the eligible server with the lowest index is granted. Index 0 has the highest priority.
- R9: `grant` is one-hot or zero, and it changes only on clock edges where `tick` is 1.
- R10: On each tick, `suspended[i]` is set to the inverse of server i's eligibility. A server that is eligible but outranked, or blocked only by refresh, is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Scheduling time unit strobe |
| refresh_pend | input | 1 | Refresh lock/unlock activity pending |
| queue_nempty | input | N_SRV | Per-server pending-work flag |
| color_lock | input | N_SRV | Per-server memory color locked by refresh |
| cfg_period | input | N_SRV x CNT_W | Period of each server, in ticks |
| cfg_budget | input | N_SRV x BUD_W | Budget of each server, in ticks |
| grant | output | N_SRV | Registered one-hot grant |
| budget_left | output | N_SRV x BUD_W | Remaining budget of each server |
| suspended | output | N_SRV | Server failed an eligibility condition at the last tick |

## Verification
If a period counter is off by one, the reload of `budget_left` lands a tick early or late. This shows at the ports at the first boundary, within one period of reset. A budget that is wrongly charged or wrongly saturated shows on the next tick as a wrong `budget_left`. A wrong eligibility term shows at the same tick, either as a grant given against a lock, an empty queue or zero budget, or as a `suspended` bit that contradicts the grant. A priority or refresh-blocking error shows in `grant` on the first tick where two servers are eligible together or where refresh is pending.

// File: rtl/srv_gate_pkg.sv
package srv_gate_pkg;
  // Lowest index wins among set request bits.
  function automatic logic [31:0] lowest_onehot(input logic [31:0] req);
    logic [31:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (req[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/srv_budget_ctr.sv
module srv_budget_ctr #(
  parameter int CNT_W = 16,
  parameter int BUD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             granted,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [BUD_W-1:0] cfg_budget,
  output logic [BUD_W-1:0] budget_q,
  output logic [BUD_W-1:0] budget_nxt
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] pos_q;
  logic             boundary;

  always_comb begin
    boundary = (({1'b0, pos_q} + EXT_W'(1)) >= {1'b0, cfg_period});
    if (boundary)
      budget_nxt = cfg_budget;
    else if (granted && (budget_q != '0))
      budget_nxt = budget_q - BUD_W'(1);
    else
      budget_nxt = budget_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      budget_q <= cfg_budget;
    end else if (tick) begin
      pos_q    <= boundary ? '0 : pos_q + CNT_W'(1);
      budget_q <= budget_nxt;
    end
  end
endmodule

// File: rtl/srv_prio_arb.sv
module srv_prio_arb #(
  parameter int N_SRV = 2
) (
  input  logic [N_SRV-1:0] req,
  input  logic             block,
  output logic [N_SRV-1:0] gnt
);
  import srv_gate_pkg::*;

  logic [31:0] wide;

  always_comb begin
    wide = lowest_onehot(32'(req));
    gnt  = block ? '0 : wide[N_SRV-1:0];
  end
endmodule

// File: rtl/srv_gate.sv
module srv_gate #(
  parameter int N_SRV = 2,
  parameter int CNT_W = 16,
  parameter int BUD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        refresh_pend,
  input  logic [N_SRV-1:0]            queue_nempty,
  input  logic [N_SRV-1:0]            color_lock,
  input  logic [N_SRV-1:0][CNT_W-1:0] cfg_period,
  input  logic [N_SRV-1:0][BUD_W-1:0] cfg_budget,
  output logic [N_SRV-1:0]            grant,
  output logic [N_SRV-1:0][BUD_W-1:0] budget_left,
  output logic [N_SRV-1:0]            suspended
);
  logic [N_SRV-1:0][BUD_W-1:0] bud_nxt;
  logic [N_SRV-1:0]            elig;
  logic [N_SRV-1:0]            gnt_nxt;

  for (genvar i = 0; i < N_SRV; i++) begin : g_srv
    srv_budget_ctr #(.CNT_W(CNT_W), .BUD_W(BUD_W)) u_bud (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .granted    (grant[i]),
      .cfg_period (cfg_period[i]),
      .cfg_budget (cfg_budget[i]),
      .budget_q   (budget_left[i]),
      .budget_nxt (bud_nxt[i])
    );
    assign elig[i] = (bud_nxt[i] != '0) && queue_nempty[i] && !color_lock[i];
  end

  srv_prio_arb #(.N_SRV(N_SRV)) u_arb (
    .req   (elig),
    .block (refresh_pend),
    .gnt   (gnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= '0;
      suspended <= '1;
    end else if (tick) begin
      grant     <= gnt_nxt;
      suspended <= ~elig;
    end
  end
endmodule

// File: rtl/srv_gate_chk.sv
module srv_gate_chk #(
  parameter int N_SRV = 2,
  parameter int BUD_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick,
  input logic                        refresh_pend,
  input logic [N_SRV-1:0]            queue_nempty,
  input logic [N_SRV-1:0]            color_lock,
  input logic [N_SRV-1:0]            grant,
  input logic [N_SRV-1:0][BUD_W-1:0] budget_left,
  input logic [N_SRV-1:0]            suspended
);
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(grant));

  a_r4_budget_idle: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(budget_left));

  a_r7_refresh_blocks: assert property (@(posedge clk) disable iff (rst)
    (tick && refresh_pend) |=> (grant == '0));

  a_r6_queue_needed: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((grant & ~$past(queue_nempty)) == '0));

  a_r6_color_unlocked: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((grant & $past(color_lock)) == '0));

  a_r10_susp_vs_grant: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((grant & suspended) == '0));

  for (genvar i = 0; i < N_SRV; i++) begin : g_bud
    a_r6_budget_nonzero: assert property (@(posedge clk) disable iff (rst)
      tick |=> (!grant[i] || (budget_left[i] != '0)));
  end
endmodule

bind srv_gate srv_gate_chk #(.N_SRV(N_SRV), .BUD_W(BUD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .refresh_pend (refresh_pend),
  .queue_nempty (queue_nempty),
  .color_lock   (color_lock),
  .grant        (grant),
  .budget_left  (budget_left),
  .suspended    (suspended)
);

// File: tb/srv_gate_tb.sv
module srv_gate_tb;
  localparam int N = 2;
  localparam int CW = 16;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic refresh_pend = 1'b0;
  logic [N-1:0] queue_nempty = '0;
  logic [N-1:0] color_lock = '0;
  logic [N-1:0][CW-1:0] cfg_period;
  logic [N-1:0][BW-1:0] cfg_budget;
  logic [N-1:0] grant;
  logic [N-1:0][BW-1:0] budget_left;
  logic [N-1:0] suspended;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  int m_pos [N];
  int m_bud [N];
  logic [N-1:0] m_grant;
  logic [N-1:0] m_susp;

  always #4 clk = ~clk;

  srv_gate #(.N_SRV(N), .CNT_W(CW), .BUD_W(BW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .refresh_pend(refresh_pend),
    .queue_nempty(queue_nempty), .color_lock(color_lock),
    .cfg_period(cfg_period), .cfg_budget(cfg_budget),
    .grant(grant), .budget_left(budget_left), .suspended(suspended)
  );

  function automatic bit is_boundary(int pos, int per);
    return (pos + 1) >= per;
  endfunction

  function automatic int next_budget(int pos, int per, int bud, int cfg, bit g);
    if (is_boundary(pos, per)) return cfg;
    if (g && bud > 0) return bud - 1;
    return bud;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_update();
    logic [N-1:0] el;
    int nb [N];
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_pos[i] = 0;
        m_bud[i] = int'(cfg_budget[i]);
      end
      m_grant = '0;
      m_susp = '1;
    end else if (tick) begin
      for (int i = 0; i < N; i++) begin
        nb[i] = next_budget(m_pos[i], int'(cfg_period[i]), m_bud[i],
                            int'(cfg_budget[i]), m_grant[i]);
        m_pos[i] = is_boundary(m_pos[i], int'(cfg_period[i])) ? 0 : m_pos[i] + 1;
        m_bud[i] = nb[i];
        el[i] = (nb[i] != 0) && queue_nempty[i] && !color_lock[i];
      end
      m_susp = ~el;
      m_grant = '0;
      if (!refresh_pend) begin
        for (int i = N - 1; i >= 0; i--)
          if (el[i]) begin
            m_grant = '0;
            m_grant[i] = 1'b1;
          end
      end
    end
  endtask

  // Inputs already set at a negedge; apply one edge and compare.
  task automatic step(string tag);
    model_update();
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8/R9 grant"}, int'(grant), int'(m_grant));
    check({tag, " R10 suspended"}, int'(suspended), int'(m_susp));
    for (int i = 0; i < N; i++)
      check({tag, " R4 budget"}, int'(budget_left[i]), m_bud[i]);
  endtask

  task automatic drive(bit t, bit rp, logic [N-1:0] q, logic [N-1:0] l, string tag);
    tick = t; refresh_pend = rp; queue_nempty = q; color_lock = l;
    step(tag);
  endtask

  task automatic do_reset(int p0, int b0, int p1, int b1);
    cfg_period[0] = CW'(p0); cfg_budget[0] = BW'(b0);
    cfg_period[1] = CW'(p1); cfg_budget[1] = BW'(b1);
    rst = 1'b1;
    drive(0, 0, '0, '0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state
    do_reset(16, 6, 16, 6);
    check("R1 grant", int'(grant), 0);
    check("R1 suspended", int'(suspended), 3);
    check("R1 budget0", int'(budget_left[0]), 6);
    check("R1 budget1", int'(budget_left[1]), 6);

    // R2/R8: default 16/6 both busy, every cycle a tick
    for (int k = 0; k < 40; k++) drive(1, 0, 2'b11, 2'b00, "R2 default");

    // R4: saturation at zero, period 8 budget 2, only server 0 busy
    do_reset(8, 2, 8, 2);
    drive(1, 0, 2'b01, 2'b00, "R4 sat");
    drive(1, 0, 2'b01, 2'b00, "R4 sat");
    drive(1, 0, 2'b01, 2'b00, "R4 sat");
    check("R4 saturated budget", int'(budget_left[0]), 0);
    drive(1, 0, 2'b01, 2'b00, "R4 sat");
    check("R4 saturated budget stays", int'(budget_left[0]), 0);
    check("R6 zero budget no grant", int'(grant), 0);

    // R5: period 3 budget 5, always granted; third tick is boundary
    do_reset(3, 5, 3, 5);
    drive(1, 0, 2'b01, 2'b00, "R5");
    drive(1, 0, 2'b01, 2'b00, "R5");
    drive(1, 0, 2'b01, 2'b00, "R5");
    check("R5 reload beats charge", int'(budget_left[0]), 5);

    // R3: server 1 idle keeps budget 4; at boundary it stays 4, not 8
    do_reset(4, 4, 4, 4);
    for (int k = 0; k < 4; k++) drive(1, 0, 2'b00, 2'b00, "R3");
    check("R3 no carry-over", int'(budget_left[1]), 4);

    // R7: refresh pending blocks both; not suspended (R10)
    drive(1, 1, 2'b11, 2'b00, "R7");
    check("R7 refresh blocks grant", int'(grant), 0);
    check("R10 refresh not suspend", int'(suspended), 0);

    // R6: lock on color 0 hands grant to server 1
    drive(1, 0, 2'b11, 2'b01, "R6");
    check("R6 locked color skipped", int'(grant), 2);
    // R8: both eligible, index 0 wins; R10 outranked not suspended
    drive(1, 0, 2'b11, 2'b00, "R8");
    check("R8 priority", int'(grant), 1);
    check("R10 outranked", int'(suspended), 0);
    // R9: no tick, grant held even though inputs change
    drive(0, 1, 2'b00, 2'b11, "R9 hold");
    check("R9 held grant", int'(grant), 1);

    // Random mix
    do_reset(16, 6, 16, 6);
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) begin
        for (int i = 0; i < N; i++) begin
          cfg_period[i] = CW'($urandom_range(0, 9));
          cfg_budget[i] = BW'($urandom_range(0, 6));
        end
      end
      drive(bit'($urandom_range(0, 2) != 0), bit'($urandom_range(0, 7) == 0),
            N'($urandom), N'($urandom_range(0, 3) == 0 ? $urandom : 0), "rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule